// File: doc/BRIEF.md
# Transmit Pause Quanta Timer

This block holds off an Ethernet transmitter after a valid flow-control pause request has been received. The upstream receive path parses the frame and presents the requested pause time on `pause_value`, qualified by a one-cycle `pause_valid` strobe. The block loads that value into a 16-bit remaining-time register and then counts it down by one quantum every 512 bit times. A single-cycle `bit_strobe` input marks each bit time, and an internal 9-bit prescaler turns 512 strobes into one quantum. While the remaining time is nonzero, `pause_active` tells the transmitter to stay quiet.

The block has two events for the interrupt logic. `pause_rx_evt` pulses once for every accepted pause request. `pause_zero_evt` pulses when a countdown runs out. Alongside the timer, a saturating 16-bit tally counts good pause frames, and the host clears it with a read strobe.

The countdown is a two-state machine. In state IDLE the remaining time is zero and the prescaler is held at zero. On a load with a nonzero value (transition START) the machine enters PAUSING. In PAUSING, a nonzero load takes transition RELOAD and stays in PAUSING with a fresh value and a restarted prescaler. A zero load takes transition CANCEL back to IDLE with no event. When the last quantum elapses, transition EXPIRE returns the machine to IDLE and raises the zero event. Any other cycle is HOLD, which leaves the state unchanged.

Top module: `pause_quanta_timer`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, every output is zero.
- R2: A cycle with `pause_valid` high loads `pause_value` into `pause_time`, visible in the next cycle, and restarts the prescaler. A `bit_strobe` in the same cycle is not counted.
- R3: While `pause_time` is nonzero, it decreases by one after every 512th `bit_strobe` counted since the last load or decrement. Strobes do nothing while `pause_time` is zero, and `pause_time` never changes in a cycle with neither strobe nor load.
- R4: When a decrement takes `pause_time` from 1 to 0, `pause_zero_evt` is high for exactly the one cycle in which `pause_time` first reads 0.
- R5: Loading a value of zero sets `pause_time` to 0 in the next cycle, ends any pause in progress, and raises no `pause_zero_evt`.
- R6: `pause_active` is high exactly when `pause_time` is nonzero.
- R7: `pause_rx_evt` is high for one cycle following each cycle in which `pause_valid` is high.
- R8: `pause_frames` increases by one for each `pause_valid` and stays at 0xFFFF once it reaches that value.
- R9: A cycle with `cnt_read` high leaves `pause_frames` at 0 in the next cycle. If `pause_valid` is also high in that cycle, it leaves `pause_frames` at 1, so that frame is not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_strobe | input | 1 | One-cycle pulse per bit time |
| pause_valid | input | 1 | One-cycle strobe: a good pause request was received |
| pause_value | input | 16 | Requested pause time in quanta |
| cnt_read | input | 1 | Host read of the pause-frame tally; clears it |
| pause_active | output | 1 | Transmission must be held off |
| pause_time | output | 16 | Remaining pause time in quanta |
| pause_zero_evt | output | 1 | Pulse: the countdown reached zero |
| pause_rx_evt | output | 1 | Pulse: a pause request was accepted |
| pause_frames | output | 16 | Saturating count of good pause frames |

## Verification
On every cycle, the assertions check the following: `pause_active` agrees with the remaining time, loads land one cycle later, the time holds steady when there is neither strobe nor load, the zero event follows only a step from 1 to 0, zero loads stay silent, and the tally saturates and clears. The 512-strobe spacing of decrements, the prescaler restart on reload, and the exact number of frames counted up to saturation depend on long histories. Only the bench's behavioural model, compared on every clock through long strobe runs, reloads mid-quantum and a 65 540-frame burst, can show these.

// File: rtl/pause_pkg.sv
package pause_pkg;
    // Countdown machine states
    typedef enum logic {
        PQ_IDLE    = 1'b0,
        PQ_PAUSING = 1'b1
    } pq_state_e;
endpackage

// File: rtl/pause_prescaler.sv
module pause_prescaler #(
    parameter int PRESC_W = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    input  logic strobe,
    output logic quantum_done
);
    localparam logic [PRESC_W-1:0] LAST = {PRESC_W{1'b1}};

    logic [PRESC_W-1:0] phase_q;

    // A quantum completes on the strobe that finds the phase at its last value
    assign quantum_done = run && strobe && !restart && (phase_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart || !run) begin
            phase_q <= '0;
        end else if (strobe) begin
            phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/pause_quanta_fsm.sv
module pause_quanta_fsm
    import pause_pkg::*;
#(
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [TIME_W-1:0] load_value,
    input  logic              quantum_done,
    output logic [TIME_W-1:0] time_left,
    output logic              active,
    output logic              zero_evt
);
    localparam logic [TIME_W-1:0] ONE = TIME_W'(1);

    pq_state_e         state_q, state_d;
    logic [TIME_W-1:0] time_q, time_d;
    logic              zero_q, zero_d;

    // Next-state and next-count selection
    always_comb begin
        state_d = state_q;
        time_d  = time_q;
        zero_d  = 1'b0;
        unique case (state_q)
            PQ_IDLE: begin
                if (load) begin                      // START (or zero load)
                    time_d  = load_value;
                    state_d = (load_value != '0) ? PQ_PAUSING : PQ_IDLE;
                end
            end
            PQ_PAUSING: begin
                if (load) begin                      // RELOAD or CANCEL
                    time_d  = load_value;
                    state_d = (load_value != '0) ? PQ_PAUSING : PQ_IDLE;
                end else if (quantum_done) begin
                    time_d = time_q - ONE;
                    if (time_q == ONE) begin         // EXPIRE
                        state_d = PQ_IDLE;
                        zero_d  = 1'b1;
                    end
                end
            end
            default: begin
                state_d = PQ_IDLE;
                time_d  = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PQ_IDLE;
            time_q  <= '0;
            zero_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            time_q  <= time_d;
            zero_q  <= zero_d;
        end
    end

    // Outputs
    always_comb begin
        active    = (state_q == PQ_PAUSING);
        time_left = time_q;
        zero_evt  = zero_q;
    end
endmodule

// File: rtl/pause_frame_tally.sv
module pause_frame_tally #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr) begin
            count_q <= inc ? CNT_W'(1) : '0;
        end else if (inc && count_q != FULL) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count = count_q;
endmodule

// File: rtl/pause_quanta_timer.sv
module pause_quanta_timer #(
    parameter int TIME_W  = 16,
    parameter int CNT_W   = 16,
    parameter int PRESC_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_strobe,
    input  logic              pause_valid,
    input  logic [TIME_W-1:0] pause_value,
    input  logic              cnt_read,
    output logic              pause_active,
    output logic [TIME_W-1:0] pause_time,
    output logic              pause_zero_evt,
    output logic              pause_rx_evt,
    output logic [CNT_W-1:0]  pause_frames
);
    logic quantum_done;
    logic active_w;
    logic rx_evt_q;

    pause_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart      (pause_valid),
        .run          (active_w),
        .strobe       (bit_strobe),
        .quantum_done (quantum_done)
    );

    pause_quanta_fsm #(.TIME_W(TIME_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (pause_valid),
        .load_value   (pause_value),
        .quantum_done (quantum_done),
        .time_left    (pause_time),
        .active       (active_w),
        .zero_evt     (pause_zero_evt)
    );

    pause_frame_tally #(.CNT_W(CNT_W)) u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (pause_valid),
        .clr   (cnt_read),
        .count (pause_frames)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) rx_evt_q <= 1'b0;
        else        rx_evt_q <= pause_valid;
    end

    assign pause_rx_evt = rx_evt_q;
    assign pause_active = active_w;
endmodule

// File: rtl/pause_quanta_timer_chk.sv
module pause_quanta_timer_chk #(
    parameter int TIME_W = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_strobe,
    input logic              pause_valid,
    input logic [TIME_W-1:0] pause_value,
    input logic              cnt_read,
    input logic              pause_active,
    input logic [TIME_W-1:0] pause_time,
    input logic              pause_zero_evt,
    input logic              pause_rx_evt,
    input logic [CNT_W-1:0]  pause_frames
);
    p_active_tracks_time_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pause_active == (pause_time != '0));

    p_load_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pause_valid |=> pause_time == $past(pause_value));

    p_hold_without_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pause_valid && !bit_strobe) |=> $stable(pause_time));

    p_zero_evt_after_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pause_zero_evt |-> (pause_time == '0 && $past(pause_time) == TIME_W'(1)));

    p_zero_load_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_valid && pause_value == '0) |=> (!pause_zero_evt && pause_time == '0));

    p_rx_evt_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pause_valid |=> pause_rx_evt);

    p_tally_saturates_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_frames == {CNT_W{1'b1}} && !cnt_read) |=> pause_frames == {CNT_W{1'b1}});

    p_tally_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_read && !pause_valid) |=> pause_frames == '0);
endmodule

bind pause_quanta_timer pause_quanta_timer_chk #(.TIME_W(TIME_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/test_pause_quanta_timer.sv
module test_pause_quanta_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_strobe = 1'b0;
    logic        pause_valid = 1'b0;
    logic [15:0] pause_value = '0;
    logic        cnt_read = 1'b0;
    logic        pause_active;
    logic [15:0] pause_time;
    logic        pause_zero_evt;
    logic        pause_rx_evt;
    logic [15:0] pause_frames;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    pause_quanta_timer i_pause_quanta_timer (
        .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe),
        .pause_valid(pause_valid), .pause_value(pause_value), .cnt_read(cnt_read),
        .pause_active(pause_active), .pause_time(pause_time),
        .pause_zero_evt(pause_zero_evt), .pause_rx_evt(pause_rx_evt),
        .pause_frames(pause_frames)
    );

    // Behavioural reference model
    int m_time = 0, m_phase = 0, m_cnt = 0;
    bit m_zero = 0, m_rx = 0;

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_time = 0; m_phase = 0; m_cnt = 0; m_zero = 0; m_rx = 0;
        end else begin
            m_zero = 0;
            m_rx   = pause_valid;
            if (pause_valid) begin
                m_time = pause_value; m_phase = 0;
            end else if (m_time != 0 && bit_strobe) begin
                if (m_phase == 511) begin
                    m_phase = 0;
                    m_time  = m_time - 1;
                    if (m_time == 0) m_zero = 1;
                end else begin
                    m_phase = m_phase + 1;
                end
            end
            if (!(m_time != 0)) m_phase = 0;
            if (cnt_read)                          m_cnt = pause_valid ? 1 : 0;
            else if (pause_valid && m_cnt < 65535) m_cnt = m_cnt + 1;
        end
    end

    task automatic check(string tag, int actual, int expected);
        vectors++;
        if (actual != expected) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, actual, expected, cycles);
        end
    endtask

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                check("R1 reset pause_time", pause_time, 0);
                check("R1 reset pause_frames", pause_frames, 0);
                check("R1 reset events", {pause_active, pause_zero_evt, pause_rx_evt}, 0);
            end else begin
                check("R2 R3 R5 pause_time", pause_time, m_time);
                check("R6 pause_active", pause_active, (m_time != 0) ? 1 : 0);
                check("R4 R5 pause_zero_evt", pause_zero_evt, m_zero);
                check("R7 pause_rx_evt", pause_rx_evt, m_rx);
                check("R8 R9 pause_frames", pause_frames, m_cnt);
            end
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic strobes(int n, int gap);
        for (int i = 0; i < n; i++) begin
            bit_strobe = 1'b1;
            @(negedge clk);
            bit_strobe = 1'b0;
            if (gap > 0) idle(gap);
        end
    endtask

    task automatic load(int v);
        pause_valid = 1'b1; pause_value = 16'(v);
        @(negedge clk);
        pause_valid = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        if (cycles > 190000 && !done) begin
            miscompares++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        idle(3);                      // R1: reset values
        rst_n = 1'b1;
        idle(2);
        load(2);                      // R2 START; R3 countdown with steady strobes
        strobes(1100, 0);             // R4 EXPIRE after 1024 strobes
        load(3);                      // R3 with gapped strobes
        strobes(300, 1);
        load(1);                      // R2 RELOAD mid-quantum restarts prescaler
        strobes(600, 2);
        load(5);
        strobes(100, 0);
        load(0);                      // R5 CANCEL with no event
        strobes(700, 0);              // R3: strobes ignored while idle
        load(1);
        strobes(511, 0);
        bit_strobe = 1'b1;            // R2: strobe coincides with load, not counted
        load(1);
        bit_strobe = 1'b0;
        strobes(520, 0);
        cnt_read = 1'b1;              // R9: plain read clears
        @(negedge clk);
        cnt_read = 1'b0;
        load(4);
        cnt_read = 1'b1;              // R9: read together with a new frame
        load(4);
        cnt_read = 1'b0;
        idle(3);
        pause_valid = 1'b1; pause_value = 16'd0;   // R8: run the tally into saturation
        idle(65540);
        pause_valid = 1'b0;
        idle(3);
        cnt_read = 1'b1;              // R9 after saturation
        @(negedge clk);
        cnt_read = 1'b0;
        idle(3);
        finish_run();
    end
endmodule